// File: doc/BRIEF.md
# Flash Write-Protection Range Checker

This block sits in front of a serial flash engine and decides, for each command cycle, whether it may run. It holds a small set of protected-range registers and one lower-bound register. Each request presents a flash address, a flag saying whether the command has an address phase, and a flag saying whether the command modifies the flash. One clock after the request the block answers with a single-cycle grant pulse or a single-cycle blocked pulse. The engine runs only granted cycles. It reports a blocked pulse as a blocked-access status in place of cycle-done.

Each protected range is an inclusive window between a base page and a limit page, with its own enable bit. A range restricts only modifying cycles that carry an address. The lower-bound register rejects every addressed cycle, read or write, that falls below the programmed address. Commands without an address phase, such as status or identification reads, are never rejected.

Software programs the registers through simple write strobes. A sticky lock input freezes all of them until reset.

Top module: `fwp_guard`

## Requirements
- R1: After reset, grant and blocked are low, every range register reads 0, the lower-bound register reads 0xFF000000, and locked is low.
- R2: A write with reg_wr_sel = 3 stores data bits 23:0 in the lower-bound register. Bits 31:24 of that register always read as ones.
- R3: A write with reg_wr_sel = i (i in 0..2) stores into range register i only bit 31 (enable), bits 27:16 (limit page, address bits 23:12) and bits 11:0 (base page, address bits 23:12). All other bits read as zero.
- R4: An enabled range covers every address from {base,12'h000} through {limit,12'hFFF}, both ends inclusive. An addressed write-class request inside it is blocked.
- R5: A range whose enable bit is clear imposes no restriction. Read-class requests are never blocked by any range.
- R6: An addressed request, read or write, whose address is below bits 23:0 of the lower-bound register is blocked.
- R7: A request with req_has_addr low is always granted.
- R8: One clock after req_valid, exactly one of grant or blocked is high, for one cycle. Neither is high in a cycle that does not follow a request.
- R9: lock_set makes locked high until reset. Register writes issued in the same cycle as lock_set, or at any time after it, leave every register unchanged.
- R10: A request issued in the same cycle as a register write is judged against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Target register: 0..2 range, 3 lower bound |
| reg_wr_data | input | 32 | Write data |
| lock_set | input | 1 | Sets the sticky lock |
| req_valid | input | 1 | Cycle request strobe |
| req_addr | input | 24 | Flash address of the cycle |
| req_has_addr | input | 1 | Command carries an address phase |
| req_write | input | 1 | Command modifies the flash |
| grant | output | 1 | Cycle may run (pulse) |
| blocked | output | 1 | Cycle rejected (pulse) |
| locked | output | 1 | Lock state |
| floor_rd | output | 32 | Lower-bound register readback |
| range_rd | output | 96 | Range registers, range i at bits 32*i+31:32*i |

## Verification
Two collisions can occur in the same clock. A register write can land in the cycle that raises lock_set, and a request can be evaluated in the cycle that rewrites the register deciding it. The bench provokes the first by writing a new lower bound together with lock_set, then confirms through the readback port that the old value survived. It provokes the second by enabling a range that covers the requested address during the request, then expects a grant followed by a block on the repeated request. The random phase also mixes writes and requests freely, and each outcome is judged against a bench model that applies the write only after the decision.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
   typedef enum logic [1:0] {
      VERDICT_NONE  = 2'b00,
      VERDICT_GRANT = 2'b01,
      VERDICT_BLOCK = 2'b10
   } verdict_e;

   // Keep-mask for a range register: enable on top, limit and base page fields.
   function automatic logic [63:0] range_keep_mask(input int reg_w, input int page_w,
                                                   input int lim_lsb);
      logic [63:0] m;
      m = '0;
      m[reg_w-1] = 1'b1;
      for (int b = 0; b < page_w; b++) begin
         m[lim_lsb+b] = 1'b1;
         m[b]         = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/fwp_range_slot.sv
module fwp_range_slot #(
   parameter int ADDR_W     = 24,
   parameter int PAGE_SHIFT = 12,
   parameter int REG_W      = 32,
   parameter int LIM_LSB    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic [REG_W-1:0]  reg_q,
   output logic              hit
);
   import fwp_pkg::*;
   localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
   localparam logic [63:0] KEEP64 = range_keep_mask(REG_W, PAGE_W, LIM_LSB);
   localparam logic [REG_W-1:0] KEEP = KEEP64[REG_W-1:0];

   logic [ADDR_W-1:0] lo_addr;
   logic [ADDR_W-1:0] hi_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     reg_q <= '0;
      else if (wr_en) reg_q <= wr_data & KEEP;
   end

   always_comb begin
      lo_addr = {reg_q[PAGE_W-1:0], {PAGE_SHIFT{1'b0}}};
      hi_addr = {reg_q[LIM_LSB +: PAGE_W], {PAGE_SHIFT{1'b1}}};
      hit     = reg_q[REG_W-1] && (chk_addr >= lo_addr) && (chk_addr <= hi_addr);
   end
endmodule

// File: rtl/fwp_floor_reg.sv
module fwp_floor_reg #(
   parameter int ADDR_W = 24,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic [REG_W-1:0]  reg_q,
   output logic              below
);
   localparam int TOP_W = REG_W - ADDR_W;

   logic [ADDR_W-1:0] bound_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bound_q <= '0;
      else if (wr_en) bound_q <= wr_addr;
   end

   assign reg_q = {{TOP_W{1'b1}}, bound_q};
   assign below = chk_addr < bound_q;
endmodule

// File: rtl/fwp_verdict.sv
module fwp_verdict (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_has_addr,
   input  logic req_write,
   input  logic below_floor,
   input  logic range_hit,
   output logic grant,
   output logic blocked
);
   import fwp_pkg::*;

   verdict_e verdict_q;
   verdict_e verdict_d;
   logic     reject;

   always_comb begin
      reject = req_has_addr && (below_floor || (req_write && range_hit));
      if (!req_valid)  verdict_d = VERDICT_NONE;
      else if (reject) verdict_d = VERDICT_BLOCK;
      else             verdict_d = VERDICT_GRANT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) verdict_q <= VERDICT_NONE;
      else        verdict_q <= verdict_d;
   end

   assign grant   = (verdict_q == VERDICT_GRANT);
   assign blocked = (verdict_q == VERDICT_BLOCK);
endmodule

// File: rtl/fwp_guard.sv
module fwp_guard #(
   parameter int ADDR_W     = 24,
   parameter int NUM_RANGES = 3,
   parameter int PAGE_SHIFT = 12,
   parameter int REG_W      = 32,
   parameter int LIM_LSB    = 16,
   localparam int SEL_W     = $clog2(NUM_RANGES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr_en,
   input  logic [SEL_W-1:0]            reg_wr_sel,
   input  logic [REG_W-1:0]            reg_wr_data,
   input  logic                        lock_set,
   input  logic                        req_valid,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic                        req_has_addr,
   input  logic                        req_write,
   output logic                        grant,
   output logic                        blocked,
   output logic                        locked,
   output logic [REG_W-1:0]            floor_rd,
   output logic [NUM_RANGES*REG_W-1:0] range_rd
);
   localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

   generate
      if (NUM_RANGES < 1)
         $error("fwp_guard: NUM_RANGES must be at least 1");
      if (REG_W <= ADDR_W || REG_W > 64)
         $error("fwp_guard: REG_W must exceed ADDR_W and not exceed 64");
      if (PAGE_W < 1 || LIM_LSB < PAGE_W || LIM_LSB + PAGE_W > REG_W - 1)
         $error("fwp_guard: page fields do not fit the range register");
   endgenerate

   logic                  lock_q;
   logic                  wr_ok;
   logic [NUM_RANGES-1:0] slot_hit;
   logic                  below_floor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock_q <= 1'b0;
      else if (lock_set) lock_q <= 1'b1;
   end

   // A write colliding with lock_set is dropped, as is any write once locked.
   assign wr_ok  = reg_wr_en && !lock_q && !lock_set;
   assign locked = lock_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_RANGES; gi++) begin : g_slot
         fwp_range_slot #(
            .ADDR_W    (ADDR_W),
            .PAGE_SHIFT(PAGE_SHIFT),
            .REG_W     (REG_W),
            .LIM_LSB   (LIM_LSB)
         ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_ok && (reg_wr_sel == SEL_W'(gi))),
            .wr_data (reg_wr_data),
            .chk_addr(req_addr),
            .reg_q   (range_rd[gi*REG_W +: REG_W]),
            .hit     (slot_hit[gi])
         );
      end
   endgenerate

   fwp_floor_reg #(
      .ADDR_W(ADDR_W),
      .REG_W (REG_W)
   ) u_floor (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok && (reg_wr_sel == SEL_W'(NUM_RANGES))),
      .wr_addr (reg_wr_data[ADDR_W-1:0]),
      .chk_addr(req_addr),
      .reg_q   (floor_rd),
      .below   (below_floor)
   );

   fwp_verdict u_verdict (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_has_addr(req_has_addr),
      .req_write   (req_write),
      .below_floor (below_floor),
      .range_hit   (|slot_hit),
      .grant       (grant),
      .blocked     (blocked)
   );
endmodule

// File: rtl/fwp_guard_chk.sv
module fwp_guard_chk #(
   parameter int ADDR_W     = 24,
   parameter int NUM_RANGES = 3,
   parameter int REG_W      = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        lock_set,
   input logic                        req_valid,
   input logic [ADDR_W-1:0]           req_addr,
   input logic                        req_has_addr,
   input logic                        grant,
   input logic                        blocked,
   input logic                        locked,
   input logic [REG_W-1:0]            floor_rd,
   input logic [NUM_RANGES*REG_W-1:0] range_rd
);
   // R8
   resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && blocked));

   // R8
   resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (grant || blocked));

   // R8
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(grant || blocked));

   // R7
   noaddr_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_has_addr) |=> grant);

   // R6
   floor_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_has_addr && (req_addr < floor_rd[ADDR_W-1:0])) |=> blocked);

   // R2
   floor_top_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      floor_rd[REG_W-1:ADDR_W] == '1);

   // R9
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R9
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked || lock_set) |=> ($stable(floor_rd) && $stable(range_rd)));
endmodule

bind fwp_guard fwp_guard_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_RANGES(NUM_RANGES),
   .REG_W     (REG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lock_set    (lock_set),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_has_addr(req_has_addr),
   .grant       (grant),
   .blocked     (blocked),
   .locked      (locked),
   .floor_rd    (floor_rd),
   .range_rd    (range_rd)
);

// File: tb/fwp_guard_bench.sv
module fwp_guard_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr_en;
   logic [1:0]  reg_wr_sel;
   logic [31:0] reg_wr_data;
   logic        lock_set;
   logic        req_valid;
   logic [23:0] req_addr;
   logic        req_has_addr;
   logic        req_write;
   logic        grant;
   logic        blocked;
   logic        locked;
   logic [31:0] floor_rd;
   logic [95:0] range_rd;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [31:0] m_rng [3];
   logic [31:0] m_floor;
   logic        m_lock;

   always #(CLK_PERIOD/2) clk = ~clk;

   fwp_guard u_fwp_guard (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
      .reg_wr_data(reg_wr_data), .lock_set(lock_set), .req_valid(req_valid),
      .req_addr(req_addr), .req_has_addr(req_has_addr), .req_write(req_write),
      .grant(grant), .blocked(blocked), .locked(locked), .floor_rd(floor_rd),
      .range_rd(range_rd)
   );

   function automatic logic exp_block(input logic [23:0] a, input logic has, input logic wr);
      if (!has) return 1'b0;
      if (a < m_floor[23:0]) return 1'b1;
      if (!wr) return 1'b0;
      for (int i = 0; i < 3; i++)
         if (m_rng[i][31] && a >= {m_rng[i][11:0], 12'h000} && a <= {m_rng[i][27:16], 12'hFFF})
            return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_regs(input string tag);
      check({tag, " floor"}, floor_rd, m_floor);
      for (int i = 0; i < 3; i++) check({tag, " range"}, range_rd[i*32 +: 32], m_rng[i]);
      check({tag, " lock"}, {31'b0, locked}, {31'b0, m_lock});
   endtask

   task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] d,
                       input logic lk, input logic rv, input logic [23:0] a,
                       input logic has, input logic wc, input string tag, input string rtag);
      logic eb;
      @(negedge clk);
      reg_wr_en = we; reg_wr_sel = sel; reg_wr_data = d; lock_set = lk;
      req_valid = rv; req_addr = a; req_has_addr = has; req_write = wc;
      eb = exp_block(a, has, wc);
      @(negedge clk);
      reg_wr_en = 0; lock_set = 0; req_valid = 0;
      if (rv) check(tag, {30'b0, blocked, grant}, eb ? 32'h2 : 32'h1);
      else    check(tag, {30'b0, blocked, grant}, 32'h0);
      if (we && !m_lock && !lk) begin
         if (sel == 2'd3) m_floor = {8'hFF, d[23:0]};
         else             m_rng[sel] = d & 32'h8FFF0FFF;
      end
      m_lock = m_lock | lk;
      check_regs(rtag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240607);
      rst_n = 0; reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0; lock_set = 0;
      req_valid = 0; req_addr = 0; req_has_addr = 0; req_write = 0;
      for (int i = 0; i < 3; i++) m_rng[i] = 32'h0;
      m_floor = 32'hFF000000; m_lock = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 resp", {30'b0, blocked, grant}, 32'h0);
      check_regs("R1");

      // R2 lower bound write, R3 range write with reserved bits set
      step(1, 2'd3, 32'h12001000, 0, 0, 0, 0, 0, "R8 idle", "R2");
      step(1, 2'd0, 32'hF01FF010, 0, 0, 0, 0, 0, "R8 idle", "R3");
      // R4 inclusive boundaries of range 0x010000..0x01FFFF
      step(0, 0, 0, 0, 1, 24'h010000, 1, 1, "R4 base", "R4");
      step(0, 0, 0, 0, 1, 24'h01FFFF, 1, 1, "R4 limit", "R4");
      step(0, 0, 0, 0, 1, 24'h00FFFF, 1, 1, "R4 below base", "R4");
      step(0, 0, 0, 0, 1, 24'h020000, 1, 1, "R4 above limit", "R4");
      // R5 read inside range passes; disabled range passes
      step(0, 0, 0, 0, 1, 24'h018000, 1, 0, "R5 read", "R5");
      step(1, 2'd1, 32'h004F0040, 0, 0, 0, 0, 0, "R8 idle", "R5");
      step(0, 0, 0, 0, 1, 24'h045000, 1, 1, "R5 disabled", "R5");
      // R6 lower bound blocks reads and writes; edge equals bound passes
      step(0, 0, 0, 0, 1, 24'h000FFF, 1, 0, "R6 read below", "R6");
      step(0, 0, 0, 0, 1, 24'h000000, 1, 1, "R6 write below", "R6");
      step(0, 0, 0, 0, 1, 24'h001000, 1, 0, "R6 at bound", "R6");
      // R7 no address phase always granted
      step(0, 0, 0, 0, 1, 24'h000000, 0, 1, "R7 noaddr", "R7");
      step(0, 0, 0, 0, 1, 24'h015000, 0, 1, "R7 noaddr in range", "R7");
      // R10 write enabling a covering range alongside the request
      step(1, 2'd2, 32'h80300030, 0, 1, 24'h030800, 1, 1, "R10 same cycle", "R10");
      step(0, 0, 0, 0, 1, 24'h030800, 1, 1, "R10 after", "R10");

      // Random phase (R4 R5 R6 R8)
      for (int it = 0; it < 400; it++) begin
         logic [31:0] d;
         logic [1:0]  s;
         s = 2'($urandom % 4);
         d = $urandom;
         if (s == 2'd3) d = $urandom % 32'h20000;
         else begin d[27:22] = 6'b0; d[11:6] = 6'b0; end
         step(($urandom % 4) == 0, s, d, 0, ($urandom % 5) != 0,
              24'($urandom % 32'h40000), ($urandom % 8) != 0, $urandom % 2,
              "R8 random", "R3 random");
      end

      // R9 write in the lock cycle is dropped, later writes ignored
      step(1, 2'd3, 32'h00FFFFFF, 1, 1, 24'h000000, 0, 0, "R9 lock cycle", "R9");
      step(1, 2'd0, 32'h00000000, 0, 0, 0, 0, 0, "R9 idle", "R9");
      step(1, 2'd3, 32'h00000000, 0, 1, 24'h000001, 1, 0, "R9 decide", "R9");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle", "R9");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule